// File: doc/BRIEF.md
# Per-CPU level interrupt aggregator

This block gathers a set of level-sensitive peripheral interrupt lines and drives one interrupt request per CPU. Every CPU owns a private bank of 32-bit enable words, one per group of 32 lines. A source reaches a CPU only when that CPU has the matching enable bit set. The same source may be enabled for several CPUs at once.

There is no priority logic and no pending queue. Software reads the status words, which show the live line levels, and works out which sources need service. Enable words are plain read/write registers, and there are no set or clear aliases.

Each CPU's registers sit in their own address window on a simple single-cycle register bus. Read data is registered and appears in the cycle after the read.

Top module: `lvl_irq_agg`

## Requirements
- R1: `N_IRQ` is 32, 64 or 128, giving NW = N_IRQ/32 enable words and NW status words per CPU. CPU c owns the byte window that starts at c*8*NW and is 8*NW bytes long, so with 128 lines a bank takes 0x20 bytes. Byte address bits [1:0] are ignored.
- R2: Byte offset 4*j, for j < NW, is enable word NW-1-j, which covers lines 32*(NW-1-j) up to 32*(NW-1-j)+31. It is read/write, and a write replaces the whole word.
- R3: Byte offset 4*(NW+j) is status word NW-1-j. It is read-only and returns the levels of its 32 input lines as sampled at the read's clock edge. Writes to it change nothing.
- R4: `cpu_irq[c]` is the OR over all lines of (irq_in AND enable of CPU c), registered. It reflects the inputs and enables present at the previous clock edge.
- R5: Addresses at or above N_CPU*8*NW are unmapped. Reads there return zero, and writes there change no enable bit.
- R6: Reset clears every enable bit in every bank, every `cpu_irq` bit and `bus_rdata`.
- R7: `bus_rdata` holds the read result in the cycle after a read (`bus_sel` high, `bus_wr` low). After any other cycle it is zero.
- R8: Banks are independent. A write to one CPU's window changes neither another CPU's enables nor its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_IRQ | Level-sensitive interrupt lines |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | N_CPU | One registered interrupt request per CPU |

## Verification
Random runs drive sparse line patterns, made by ANDing several random words, against random enable masks. These runs show whether an output fires only when an enabled line is truly high, and not merely when some line or some enable is set. Dense all-ones enables with a single active line, placed at bit 0 and then at the top bit, show whether the word order inside a window and the slice boundaries are decoded correctly. Writes aimed at status offsets, at unmapped windows and at one CPU's bank, each followed by read-back of every bank, show whether a write leaks into an enable word it should not touch.

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg #(
  parameter int N_IRQ  = 128,
  parameter int N_CPU  = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_CPU-1:0]  cpu_irq
);
  localparam int NW = N_IRQ / 32;
  localparam int WB = $clog2(2 * NW);
  localparam int CB = ADDR_W - WB - 2;

  logic [N_IRQ-1:0] en_q [N_CPU];
  logic [WB-1:0]    woff, widx;
  logic [CB-1:0]    cidx;
  logic             hit, is_en, wr_go, rd_go;
  logic [31:0]      rd_word;
  logic [N_CPU-1:0] any_c;
  wire              unused_lsb = &{1'b0, bus_addr[1:0]};

  assign woff  = bus_addr[WB+1:2];
  assign cidx  = bus_addr[ADDR_W-1:WB+2];
  assign hit   = int'(cidx) < N_CPU;
  assign is_en = int'(woff) < NW;
  assign widx  = is_en ? WB'(NW - 1) - woff : WB'(2 * NW - 1) - woff;
  assign wr_go = bus_sel && bus_wr && hit && is_en;
  assign rd_go = bus_sel && !bus_wr && hit;

  always_ff @(posedge clk) begin
    for (int c = 0; c < N_CPU; c++) begin
      if (!rst_n)
        en_q[c] <= '0;
      else if (wr_go && int'(cidx) == c)
        en_q[c][widx*32 +: 32] <= bus_wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < N_CPU; c++)
      if (int'(cidx) == c)
        rd_word = is_en ? en_q[c][widx*32 +: 32] : irq_in[widx*32 +: 32];
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    assign any_c[c] = |(irq_in & en_q[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_irq   <= '0;
      bus_rdata <= '0;
    end else begin
      cpu_irq   <= any_c;
      bus_rdata <= rd_go ? rd_word : 32'd0;
    end
  end
endmodule

// File: rtl/lvl_irq_agg_chk.sv
module lvl_irq_agg_chk #(
  parameter int N_IRQ  = 128,
  parameter int N_CPU  = 3,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_IRQ-1:0]  irq_in,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [N_CPU-1:0]  cpu_irq
);
  localparam int NW   = N_IRQ / 32;
  localparam int WB   = $clog2(2 * NW);
  localparam int WINB = 8 * NW;

  logic          rd, unm, is_stat;
  logic [WB-1:0] woff, sidx;
  logic [31:0]   stat_val;

  assign rd       = bus_sel && !bus_wr;
  assign unm      = int'(bus_addr) >= N_CPU * WINB;
  assign woff     = bus_addr[WB+1:2];
  assign is_stat  = int'(woff) >= NW;
  assign sidx     = WB'(2 * NW - 1) - woff;
  assign stat_val = irq_in[sidx*32 +: 32];

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cpu_irq == '0 && bus_rdata == '0)); // R6
  AST_NO_LINE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_in) == '0) |-> (cpu_irq == '0)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd && unm) |-> (bus_rdata == 32'd0)); // R5
  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd && !unm && is_stat) |-> (bus_rdata == $past(stat_val))); // R3
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd) |-> (bus_rdata == 32'd0)); // R7
endmodule

bind lvl_irq_agg lvl_irq_agg_chk #(.N_IRQ(N_IRQ), .N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
);

// File: tb/tb_lvl_irq_agg.sv
module tb_lvl_irq_agg;
  localparam int N_IRQ = 128;
  localparam int N_CPU = 3;
  localparam int NW    = N_IRQ / 32;
  localparam int WINB  = 8 * NW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_IRQ-1:0] irq_in = '0;
  logic             bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [N_CPU-1:0] cpu_irq;

  logic [N_IRQ-1:0] m_en [N_CPU];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lvl_irq_agg dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

  function automatic logic [7:0] en_addr(int c, int k);
    return 8'(c * WINB + 4 * (NW - 1 - k));
  endfunction
  function automatic logic [7:0] st_addr(int c, int k);
    return 8'(c * WINB + 4 * (2 * NW - 1 - k));
  endfunction
  function automatic logic [N_CPU-1:0] exp_irq();
    logic [N_CPU-1:0] v;
    for (int c = 0; c < N_CPU; c++) v[c] = |(irq_in & m_en[c]);
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic irq_chk(string req);
    @(negedge clk);
    @(negedge clk);
    chk(req, 32'(cpu_irq), 32'(exp_irq()));
  endtask

  task automatic all_en_chk(string req);
    for (int c = 0; c < N_CPU; c++)
      for (int k = 0; k < NW; k++)
        rd_chk(req, en_addr(c, k), m_en[c][k*32 +: 32]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1; n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < N_CPU; c++) m_en[c] = '0;
    repeat (3) @(negedge clk);
    chk("R6 cpu_irq in reset", 32'(cpu_irq), 0);
    chk("R6 rdata in reset", bus_rdata, 0);
    rst_n = 1;
    irq_in = '1;
    irq_chk("R6 enables cleared");
    all_en_chk("R6 enable words zero");

    // R2 word order: single top and bottom line
    irq_in = '0; irq_in[0] = 1'b1;
    m_en[0] = '0; m_en[0][0] = 1'b1;
    wr(en_addr(0, 0), 32'h1);
    irq_chk("R2 bit0 reaches cpu0");
    irq_in = '0; irq_in[N_IRQ-1] = 1'b1;
    irq_chk("R4 top line not enabled");
    m_en[0][N_IRQ-1] = 1'b1;
    wr(en_addr(0, NW - 1), 32'h8000_0001 & 32'h8000_0000);
    irq_chk("R2 top line via offset 0");
    rd_chk("R1 offset 0 is top enable word", 8'h00, 32'h8000_0000);

    // R8 independence
    m_en[1] = '1;
    for (int k = 0; k < NW; k++) wr(en_addr(1, k), 32'hFFFF_FFFF);
    irq_in = '0; irq_in[40] = 1'b1;
    irq_chk("R8 cpu1 only");
    all_en_chk("R8 banks unchanged");

    // R3 writes to status ignored, status read live
    irq_in = {4{32'hA5C3_0F1E}};
    for (int k = 0; k < NW; k++) wr(st_addr(2, k), 32'hFFFF_FFFF);
    all_en_chk("R3 status write ignored");
    irq_chk("R3 cpu2 still quiet");
    rd_chk("R3 status word live", st_addr(0, 2), 32'hA5C3_0F1E);

    // R1 byte lanes ignored
    rd_chk("R1 addr[1:0] ignored", 8'(en_addr(1, 3) | 8'h3), 32'hFFFF_FFFF);

    // R5 unmapped
    wr(8'(N_CPU * WINB), 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    all_en_chk("R5 unmapped write ignored");
    rd_chk("R5 unmapped read zero", 8'(N_CPU * WINB + 4 * NW), 32'h0);

    // R7 idle rdata
    rd_chk("R7 read data", en_addr(1, 0), 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R7 idle rdata zero", bus_rdata, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op, c, k;
      op = int'($urandom_range(0, 3));
      c  = int'($urandom_range(0, N_CPU - 1));
      k  = int'($urandom_range(0, NW - 1));
      case (op)
        0: begin
          logic [31:0] d;
          d = $urandom() & $urandom();
          m_en[c][k*32 +: 32] = d;
          wr(en_addr(c, k), d);
        end
        1: begin
          for (int w = 0; w < NW; w++)
            irq_in[w*32 +: 32] = $urandom() & $urandom() & $urandom();
          irq_chk("R4 random output");
        end
        2: rd_chk("R2 random enable readback", en_addr(c, k), m_en[c][k*32 +: 32]);
        default: rd_chk("R3 random status read", st_addr(c, k), irq_in[k*32 +: 32]);
      endcase
    end
    irq_chk("R4 final output");

    // R6 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int c = 0; c < N_CPU; c++) m_en[c] = '0;
    irq_in = '1;
    irq_chk("R6 reset clears enables");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule